// File: doc/BRIEF.md
# Lane Synchronization Controller

This controller sits after the 8b/10b decoder of one receive lane of a multi-lane serial converter link. On every character clock it takes one decoded character: an octet, a flag marking a control character, and two decoder error flags. From these it steps through four phases. It waits for a comma. It counts commas until code-group synchronization is reached. It walks the four-multiframe initial alignment sequence. Finally it settles into user data.

During the alignment sequence it checks the framing of every multiframe. The multiframe length is the product of the run-time frame length and the frames-per-multiframe count. The controller also stores the fourteen configuration octets carried in the second multiframe, and declares them valid at the start of the third multiframe if their checksum agrees.

Framing faults and checksum faults are fatal: the lane falls back to its idle phase and flags an uncorrectable error. Decoder faults and faults reported by the external lane and frame aligners while in data only raise a sticky correctable error. A resynchronization request wins over everything and returns the lane to idle.

Top module: `lsync_ctrl`

## Requirements
- R1: After reset, link_state is 0 (idle). synced, corr_err, uncorr_err and cfg_valid are 0, and cfg_data is all zero. The state codes are 0 idle, 1 comma-sync, 2 alignment, 3 data.
- R2: In idle, a control character with octet 0xBC moves link_state to 1 on the same clock edge that samples it. Any other character leaves the lane in idle.
- R3: In comma-sync, synced rises on the edge that samples the fifth consecutive 0xBC control character, counting the one that left idle. Before that, any other character restarts the count and keeps link_state at 1. Once synced, a character that is neither 0xBC nor 0x1C (both as control characters) clears synced and restarts the count, and link_state stays at 1.
- R4: While synced in comma-sync, a control character 0x1C moves link_state to 2. That character is octet 0 of the first multiframe.
- R5: In alignment, each multiframe is frame_len × mf_len characters long. Octet 0 must be control 0x1C and the last octet must be control 0x7C. Any violation sends the lane to idle with synced cleared and uncorr_err set.
- R6: In the second multiframe, octet 1 must be control 0x9C, or the fault of R5 applies. Octets 2 to 15 are stored into cfg_data: octet 2 lands in bits [7:0], octet 3 in bits [15:8], and so on up to bits [111:104].
- R7: On the edge that samples the 0x1C opening the third multiframe, the stored checksum octet (bits [111:104]) is compared with the modulo-256 sum of the other thirteen stored octets. On a match, cfg_valid rises. On a mismatch, the fault of R5 applies.
- R8: The character after the 0x7C that closes the fourth multiframe, whatever its value, moves link_state to 3. synced stays 1 throughout.
- R9: In data, disp_err, nit_err, lane_err or frame_err sets corr_err from the next edge. corr_err stays set until resync, and link_state and synced are unaffected.
- R10: resync takes priority over all other inputs. On the next edge it puts the lane in idle and clears synced, corr_err, uncorr_err and cfg_valid. While resync is held, 0xBC is ignored. After release, the lane again waits for 0xBC.
- R11: uncorr_err stays set in idle and is cleared on the edge that moves the lane into comma-sync.
- R12: Outside data, the four error inputs have no effect on corr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_len | input | 9 | Octets per frame (1..256) |
| mf_len | input | 6 | Frames per multiframe (1..32) |
| resync | input | 1 | Resynchronization request, level |
| char_octet | input | 8 | Decoded octet |
| char_k | input | 1 | Octet is a control character |
| disp_err | input | 1 | Running disparity error from decoder |
| nit_err | input | 1 | Not-in-table error from decoder |
| lane_err | input | 1 | Fault from the external lane aligner |
| frame_err | input | 1 | Fault from the external frame aligner |
| link_state | output | 2 | Current phase, encoded as in R1 |
| synced | output | 1 | Code-group synchronization reached |
| corr_err | output | 1 | Sticky correctable error in data |
| uncorr_err | output | 1 | Fatal alignment or checksum fault |
| cfg_valid | output | 1 | cfg_data holds a checked configuration |
| cfg_data | output | 112 | Fourteen captured configuration octets |

## Verification
The bound checker watches the single-step rules on every cycle. These are the exits from idle and comma-sync, the effect of resync, synced being held in data, corr_err being confined to data, and the conditions under which uncorr_err and cfg_valid may rise. What no one-cycle property can cover are the long-range sequences: the fifth-comma count, framing over a full run-time multiframe length, storage of the configuration octets at the right positions, and the checksum decision two multiframes later. The bench's reference model covers these. It drives complete alignment sequences with several frame and multiframe lengths, correct and corrupted checksums, a missing end marker, and a wrong marker after the start of the second multiframe.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CSYNC = 2'd1,
    ST_ALIGN = 2'd2,
    ST_DATA = 2'd3
  } lsync_state_e;

  localparam logic [7:0] OCT_COMMA    = 8'hBC;
  localparam logic [7:0] OCT_MF_OPEN  = 8'h1C;
  localparam logic [7:0] OCT_MF_CLOSE = 8'h7C;
  localparam logic [7:0] OCT_CFG_MARK = 8'h9C;
endpackage

// File: rtl/lsync_char_class.sv
module lsync_char_class
  import lsync_pkg::*;
(
  input  logic [7:0] octet,
  input  logic       is_k,
  output logic       comma,
  output logic       mf_open,
  output logic       mf_close,
  output logic       cfg_mark
);
  always_comb begin
    comma    = is_k && (octet == OCT_COMMA);
    mf_open  = is_k && (octet == OCT_MF_OPEN);
    mf_close = is_k && (octet == OCT_MF_CLOSE);
    cfg_mark = is_k && (octet == OCT_CFG_MARK);
  end
endmodule

// File: rtl/lsync_mf_track.sv
module lsync_mf_track #(
  parameter int F_W  = 9,
  parameter int K_W  = 6,
  parameter int N_MF = 4,
  localparam int POS_W = F_W + K_W,
  localparam int MF_W  = $clog2(N_MF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [F_W-1:0]   frame_len,
  input  logic [K_W-1:0]   mf_len,
  input  logic             clr,
  input  logic             first,
  input  logic             wrap,
  input  logic             adv,
  output logic [POS_W-1:0] pos,
  output logic [MF_W-1:0]  mf_idx,
  output logic             pos_zero,
  output logic             pos_one,
  output logic             pos_last
);
  logic [POS_W-1:0] pos_q, pos_n, total;
  logic [MF_W-1:0]  mf_q, mf_n;

  always_comb begin
    total = POS_W'(frame_len) * POS_W'(mf_len);
    pos_n = pos_q;
    mf_n  = mf_q;
    if (clr) begin
      pos_n = '0;
      mf_n  = '0;
    end else if (first) begin
      pos_n = POS_W'(1);
      mf_n  = '0;
    end else if (wrap) begin
      pos_n = '0;
      mf_n  = mf_q + 1'b1;
    end else if (adv) begin
      pos_n = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      mf_q  <= '0;
    end else begin
      pos_q <= pos_n;
      mf_q  <= mf_n;
    end
  end

  assign pos      = pos_q;
  assign mf_idx   = mf_q;
  assign pos_zero = (pos_q == '0);
  assign pos_one  = (pos_q == POS_W'(1));
  assign pos_last = (pos_q == total - POS_W'(1));
endmodule

// File: rtl/lsync_cfg_store.sv
module lsync_cfg_store #(
  parameter int N_OCT = 14,
  localparam int IDX_W = $clog2(N_OCT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  output logic [N_OCT*8-1:0] cfg_flat,
  output logic               sum_ok
);
  logic [7:0] oct_q [N_OCT];
  logic [7:0] acc;

  for (genvar g = 0; g < N_OCT; g++) begin : g_oct
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oct_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        oct_q[g] <= wr_data;
      end
    end
    assign cfg_flat[g*8 +: 8] = oct_q[g];
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_OCT - 1; i++) acc = acc + oct_q[i];
  end

  assign sum_ok = (acc == oct_q[N_OCT-1]);
endmodule

// File: rtl/lsync_ctrl.sv
module lsync_ctrl
  import lsync_pkg::*;
#(
  parameter int F_W      = 9,
  parameter int K_W      = 6,
  parameter int SYNC_RUN = 5,
  parameter int N_MF     = 4,
  parameter int N_OCT    = 14,
  localparam int POS_W = F_W + K_W,
  localparam int MF_W  = $clog2(N_MF),
  localparam int RUN_W = $clog2(SYNC_RUN + 1),
  localparam int IDX_W = $clog2(N_OCT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [F_W-1:0]     frame_len,
  input  logic [K_W-1:0]     mf_len,
  input  logic               resync,
  input  logic [7:0]         char_octet,
  input  logic               char_k,
  input  logic               disp_err,
  input  logic               nit_err,
  input  logic               lane_err,
  input  logic               frame_err,
  output logic [1:0]         link_state,
  output logic               synced,
  output logic               corr_err,
  output logic               uncorr_err,
  output logic               cfg_valid,
  output logic [N_OCT*8-1:0] cfg_data
);
  lsync_state_e     state_q, state_n;
  logic             sync_q, sync_n, corr_q, corr_n, unc_q, unc_n, cfgv_q, cfgv_n;
  logic             done_q, done_n;
  logic [RUN_W-1:0] run_q, run_n;

  logic comma, mf_open, mf_close, cfg_mark;
  logic trk_clr, trk_first, trk_wrap, trk_adv;
  logic [POS_W-1:0] pos;
  logic [MF_W-1:0]  mf_idx;
  logic pos_zero, pos_one, pos_last;
  logic cfg_we, sum_ok, in_win, fault;
  logic [POS_W-1:0] pos_off;

  lsync_char_class u_class (
    .octet(char_octet), .is_k(char_k), .comma(comma),
    .mf_open(mf_open), .mf_close(mf_close), .cfg_mark(cfg_mark)
  );

  lsync_mf_track #(.F_W(F_W), .K_W(K_W), .N_MF(N_MF)) u_track (
    .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .mf_len(mf_len),
    .clr(trk_clr), .first(trk_first), .wrap(trk_wrap), .adv(trk_adv),
    .pos(pos), .mf_idx(mf_idx), .pos_zero(pos_zero), .pos_one(pos_one),
    .pos_last(pos_last)
  );

  assign pos_off = pos - POS_W'(2);
  assign in_win  = (pos >= POS_W'(2)) && (pos < POS_W'(N_OCT + 2));

  lsync_cfg_store #(.N_OCT(N_OCT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(IDX_W'(pos_off)),
    .wr_data(char_octet), .cfg_flat(cfg_data), .sum_ok(sum_ok)
  );

  always_comb begin
    state_n   = state_q;
    sync_n    = sync_q;
    corr_n    = corr_q;
    unc_n     = unc_q;
    cfgv_n    = cfgv_q;
    run_n     = run_q;
    done_n    = done_q;
    trk_clr   = 1'b0;
    trk_first = 1'b0;
    trk_wrap  = 1'b0;
    trk_adv   = 1'b0;
    cfg_we    = 1'b0;
    fault     = 1'b0;
    if (resync) begin
      state_n = ST_IDLE;
      sync_n  = 1'b0;
      corr_n  = 1'b0;
      unc_n   = 1'b0;
      cfgv_n  = 1'b0;
      run_n   = '0;
      done_n  = 1'b0;
      trk_clr = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (comma) begin
          state_n = ST_CSYNC;
          run_n   = RUN_W'(1);
          unc_n   = 1'b0;
        end
        ST_CSYNC: begin
          if (comma) begin
            if (run_q != RUN_W'(SYNC_RUN)) run_n = run_q + 1'b1;
            if (run_q >= RUN_W'(SYNC_RUN - 1)) sync_n = 1'b1;
          end else if (mf_open && sync_q) begin
            state_n   = ST_ALIGN;
            trk_first = 1'b1;
            done_n    = 1'b0;
          end else begin
            run_n  = '0;
            sync_n = 1'b0;
          end
        end
        ST_ALIGN: begin
          if (done_q) begin
            state_n = ST_DATA;
            done_n  = 1'b0;
          end else if (pos_zero) begin
            trk_adv = 1'b1;
            if (!mf_open) fault = 1'b1;
            else if (mf_idx == MF_W'(2)) begin
              if (sum_ok) cfgv_n = 1'b1;
              else fault = 1'b1;
            end
          end else if (pos_last) begin
            if (!mf_close) fault = 1'b1;
            else if (mf_idx == MF_W'(N_MF - 1)) done_n = 1'b1;
            else trk_wrap = 1'b1;
          end else begin
            trk_adv = 1'b1;
            if ((mf_idx == MF_W'(1)) && pos_one && !cfg_mark) fault = 1'b1;
            cfg_we = (mf_idx == MF_W'(1)) && in_win;
          end
          if (fault) begin
            state_n = ST_IDLE;
            sync_n  = 1'b0;
            unc_n   = 1'b1;
            cfgv_n  = 1'b0;
            run_n   = '0;
            done_n  = 1'b0;
            trk_clr = 1'b1;
          end
        end
        ST_DATA: if (disp_err || nit_err || lane_err || frame_err) corr_n = 1'b1;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sync_q  <= 1'b0;
      corr_q  <= 1'b0;
      unc_q   <= 1'b0;
      cfgv_q  <= 1'b0;
      run_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      sync_q  <= sync_n;
      corr_q  <= corr_n;
      unc_q   <= unc_n;
      cfgv_q  <= cfgv_n;
      run_q   <= run_n;
      done_q  <= done_n;
    end
  end

  assign link_state = state_q;
  assign synced     = sync_q;
  assign corr_err   = corr_q;
  assign uncorr_err = unc_q;
  assign cfg_valid  = cfgv_q;
endmodule

// File: rtl/lsync_ctrl_chk.sv
module lsync_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       resync,
  input logic [7:0] char_octet,
  input logic       char_k,
  input logic       disp_err,
  input logic       nit_err,
  input logic       lane_err,
  input logic       frame_err,
  input logic [1:0] link_state,
  input logic       synced,
  input logic       corr_err,
  input logic       uncorr_err,
  input logic       cfg_valid
);
  logic is_comma, is_open, any_err;
  assign is_comma = char_k && (char_octet == 8'hBC);
  assign is_open  = char_k && (char_octet == 8'h1C);
  assign any_err  = disp_err || nit_err || lane_err || frame_err;

  AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && !resync && is_comma) |=> link_state == 2'd1); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && !is_comma) |=> link_state == 2'd0); // R2
  AST_CSYNC_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd1 && !resync && !is_comma && !(is_open && synced))
      |=> (link_state == 2'd1 && !synced)); // R3
  AST_CSYNC_TO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd1 && synced && !resync && is_open) |=> link_state == 2'd2); // R4
  AST_FAULT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uncorr_err) |-> (link_state == 2'd0 && !synced && !cfg_valid)); // R5
  AST_CFGV_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (link_state == 2'd2 || link_state == 2'd3)); // R7
  AST_DATA_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
    link_state == 2'd3 |-> synced); // R8
  AST_DATA_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd3 && !resync && any_err) |=> (corr_err && link_state == 2'd3)); // R9
  AST_RESYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (link_state == 2'd0 && !synced && !corr_err && !uncorr_err && !cfg_valid)); // R10
  AST_UNCORR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && !resync && is_comma) |=> !uncorr_err); // R11
  AST_CORR_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    corr_err |-> link_state == 2'd3); // R12
endmodule

bind lsync_ctrl lsync_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .resync(resync), .char_octet(char_octet),
  .char_k(char_k), .disp_err(disp_err), .nit_err(nit_err),
  .lane_err(lane_err), .frame_err(frame_err), .link_state(link_state),
  .synced(synced), .corr_err(corr_err), .uncorr_err(uncorr_err),
  .cfg_valid(cfg_valid)
);

// File: tb/lsync_ctrl_test.sv
`timescale 1ns/1ps
module lsync_ctrl_test;
  logic         clk, rst_n;
  logic [8:0]   frame_len;
  logic [5:0]   mf_len;
  logic         resync, char_k, disp_err, nit_err, lane_err, frame_err;
  logic [7:0]   char_octet;
  logic [1:0]   link_state;
  logic         synced, corr_err, uncorr_err, cfg_valid;
  logic [111:0] cfg_data;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // reference model state
  int m_st, m_sync, m_corr, m_unc, m_cfgv, m_run, m_pos, m_mf, m_done;
  logic [7:0] m_cfg [14];
  logic [7:0] tx_cfg [14];

  lsync_ctrl uut (
    .clk(clk), .rst_n(rst_n), .frame_len(frame_len), .mf_len(mf_len),
    .resync(resync), .char_octet(char_octet), .char_k(char_k),
    .disp_err(disp_err), .nit_err(nit_err), .lane_err(lane_err),
    .frame_err(frame_err), .link_state(link_state), .synced(synced),
    .corr_err(corr_err), .uncorr_err(uncorr_err), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [111:0] model_cfg();
    logic [111:0] v;
    for (int i = 0; i < 14; i++) v[i*8 +: 8] = m_cfg[i];
    return v;
  endfunction

  task automatic model_fault();
    m_st = 0; m_sync = 0; m_unc = 1; m_cfgv = 0; m_run = 0;
    m_done = 0; m_pos = 0; m_mf = 0;
  endtask

  task automatic model_step(input logic [7:0] o, input bit k, input bit errs,
                            input bit rs);
    bit is_c, is_r, is_a, is_q;
    int len, s;
    is_c = k && o == 8'hBC;
    is_r = k && o == 8'h1C;
    is_a = k && o == 8'h7C;
    is_q = k && o == 8'h9C;
    len  = int'(frame_len) * int'(mf_len);
    if (rs) begin
      m_st = 0; m_sync = 0; m_corr = 0; m_unc = 0; m_cfgv = 0;
      m_run = 0; m_done = 0; m_pos = 0; m_mf = 0;
    end else if (m_st == 0) begin
      if (is_c) begin m_st = 1; m_run = 1; m_unc = 0; end
    end else if (m_st == 1) begin
      if (is_c) begin
        if (m_run < 5) m_run++;
        if (m_run >= 5) m_sync = 1;
      end else if (is_r && m_sync == 1) begin
        m_st = 2; m_pos = 1; m_mf = 0; m_done = 0;
      end else begin
        m_run = 0; m_sync = 0;
      end
    end else if (m_st == 2) begin
      if (m_done == 1) begin
        m_st = 3; m_done = 0;
      end else if (m_pos == 0) begin
        if (!is_r) model_fault();
        else begin
          m_pos = 1;
          if (m_mf == 2) begin
            s = 0;
            for (int i = 0; i < 13; i++) s += m_cfg[i];
            if ((s % 256) == m_cfg[13]) m_cfgv = 1;
            else model_fault();
          end
        end
      end else if (m_pos == len - 1) begin
        if (!is_a) model_fault();
        else if (m_mf == 3) m_done = 1;
        else begin m_mf++; m_pos = 0; end
      end else begin
        if (m_mf == 1 && m_pos == 1 && !is_q) model_fault();
        else begin
          if (m_mf == 1 && m_pos >= 2 && m_pos < 16) m_cfg[m_pos-2] = o;
          m_pos++;
        end
      end
    end else begin
      if (errs) m_corr = 1;
    end
  endtask

  task automatic compare();
    logic [111:0] ec;
    ec = model_cfg();
    n_cmp++;
    if (int'(link_state) != m_st || synced != m_sync[0] || corr_err != m_corr[0] ||
        uncorr_err != m_unc[0] || cfg_valid != m_cfgv[0] || cfg_data != ec) begin
      n_bad++;
      $display("FAIL %s: act st=%0d sy=%0b ce=%0b ue=%0b cv=%0b cfg=%h exp st=%0d sy=%0d ce=%0d ue=%0d cv=%0d cfg=%h",
               cur_req, link_state, synced, corr_err, uncorr_err, cfg_valid, cfg_data,
               m_st, m_sync, m_corr, m_unc, m_cfgv, ec);
    end
  endtask

  task automatic step(input logic [7:0] o, input bit k, input bit de = 0,
                      input bit ne = 0, input bit le = 0, input bit fe = 0,
                      input bit rs = 0);
    char_octet = o; char_k = k; disp_err = de; nit_err = ne;
    lane_err = le; frame_err = fe; resync = rs;
    model_step(o, k, de || ne || le || fe, rs);
    @(negedge clk);
    compare();
  endtask

  task automatic comma_run(input int n);
    for (int i = 0; i < n; i++) step(8'hBC, 1);
  endtask

  task automatic fill_cfg(input int seed, input bit bad_sum);
    int s;
    s = 0;
    for (int i = 0; i < 13; i++) begin
      tx_cfg[i] = 8'((i * 29 + seed * 7 + 3) % 256);
      s += tx_cfg[i];
    end
    tx_cfg[13] = 8'(s % 256) ^ (bad_sum ? 8'h01 : 8'h00);
  endtask

  // four multiframes; optional wrong marker and missing close in a chosen multiframe
  task automatic send_align(input bit bad_mark, input int miss_close_mf);
    int len;
    len = int'(frame_len) * int'(mf_len);
    for (int mf = 0; mf < 4; mf++) begin
      cur_req = (mf == 0) ? "R4" : (mf == 1) ? "R6" : (mf == 2) ? "R7" : "R5";
      step(8'h1C, 1);
      for (int p = 1; p < len - 1; p++) begin
        if (mf == 1 && p == 1) begin
          if (bad_mark) step(8'h55, 0); else step(8'h9C, 1);
        end else if (mf == 1 && p >= 2 && p < 16) step(tx_cfg[p-2], 0);
        else step(8'((p * 3 + mf) % 256), 0);
      end
      if (miss_close_mf == mf) step(8'h00, 0); else step(8'h7C, 1);
    end
    cur_req = "R8";
    step(8'h5A, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; resync = 0; char_octet = 0; char_k = 0;
    disp_err = 0; nit_err = 0; lane_err = 0; frame_err = 0;
    frame_len = 9'd17; mf_len = 6'd1;
    m_st = 0; m_sync = 0; m_corr = 0; m_unc = 0; m_cfgv = 0;
    m_run = 0; m_pos = 0; m_mf = 0; m_done = 0;
    for (int i = 0; i < 14; i++) m_cfg[i] = 8'h00;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1;
    @(negedge clk);
    compare();

    cur_req = "R2";
    step(8'h00, 0); step(8'hBC, 0); step(8'h1C, 1);
    step(8'hBC, 1);
    cur_req = "R3";
    comma_run(2); step(8'h11, 0);
    comma_run(5);
    step(8'h22, 0);
    cur_req = "R12";
    step(8'hBC, 1, 1, 1, 1, 1);
    cur_req = "R3";
    comma_run(4);

    fill_cfg(1, 0);
    send_align(0, -1);
    cur_req = "R9";
    step(8'h10, 0); step(8'h11, 0, 0, 1); step(8'h12, 0);
    step(8'h13, 0, 0, 0, 1); step(8'h14, 0, 0, 0, 0, 1); step(8'h15, 0, 1);

    cur_req = "R10";
    step(8'hBC, 1, 0, 0, 0, 0, 1); step(8'hBC, 1, 0, 0, 0, 0, 1);
    step(8'h00, 0); step(8'hBC, 1);
    comma_run(4);

    cur_req = "R7";
    fill_cfg(2, 1);
    send_align(0, -1);
    cur_req = "R11";
    step(8'h00, 0); step(8'hBC, 1); comma_run(4);

    frame_len = 9'd4; mf_len = 6'd5;
    fill_cfg(3, 0);
    cur_req = "R5";
    send_align(0, 0);
    step(8'hBC, 1); comma_run(4);
    send_align(0, 3);
    step(8'hBC, 1); comma_run(4);
    send_align(1, -1);

    cur_req = "R6";
    frame_len = 9'd2; mf_len = 6'd9;
    fill_cfg(4, 0);
    step(8'hBC, 1); comma_run(4);
    send_align(0, -1);
    cur_req = "R9";
    step(8'h77, 0); step(8'h78, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule